// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and gives each processor of a small cluster a 4-bit interrupt level. Software sets it up through a 32-bit register port with a separate setup and access phase. Shared registers hold a priority-group selection, the pending requests, a clear port and a broadcast selection. Each processor also has its own mask register and its own force register.

A request pulse on an incoming line sets that line's pending bit. If the line is marked for broadcast, the pulse instead sets the line's bit in the force register of every processor. Each processor sees the lines that are pending or forced for it and that its mask enables. Lines assigned to the high group win over all other lines. Within the chosen group the highest line number is presented. When a processor takes an interrupt it pulses its acknowledge input with the line number, and that line is removed from the shared pending register and from that processor's force register.

The processor count is a parameter. Bit 0 of every register is reserved and always holds zero.

Top module: `irq_hub`

## Requirements
- R1: Only bits 15:1 carry interrupt lines. Bit 0 of the level, broadcast, mask and force registers and of the pending register is always 0, whatever value is written. Level, broadcast and mask writes keep bits 15:1 of the written word and drop all other bits.
- R2: Register offsets (byte address, 32-bit word access only): level group select 0x00, pending 0x04, processor-0 force alias 0x08, clear 0x0C, status 0x10, broadcast select 0x14, mask of processor n at 0x40+4n, force of processor n at 0x80+4n, and a 4-bit spare field of processor n at 0xC0+4n. A write takes effect on the access-phase clock edge (psel, penable and pwrite all high). Read data is valid during the access phase.
- R3: The active set of processor n is (pending OR force[n]) AND mask[n].
- R4: If any active line of a processor has its level bit set to 1, only those lines are candidates for that processor. Otherwise all of its active lines are candidates.
- R5: The level output of processor n is cpu_level[4n+3:4n]. It carries the highest candidate line number, or 0 when no line is active. It follows a register change or an incoming request one clock after that change is stored.
- R6: An incoming pulse on line k whose broadcast bit is set sets bit k in every processor's force register and leaves pending unchanged. If the broadcast bit is clear, the pulse sets pending bit k.
- R7: A write to the force register of processor n treats bits 15:1 of the word as set bits and bits 31:17 as clear bits (clear bit 16+k clears line k). The new value is (old OR set) AND NOT clear.
- R8: A write to the 0x08 alias replaces the whole force register of processor 0 with bits 15:1 of the word. A read of 0x08 returns that register.
- R9: A write to the clear register removes the written lines from pending and from processor 0's force register. A read of the clear register returns 0.
- R10: An acknowledge pulse from processor n carrying number k clears bit k in pending and in force[n], and no other bits. The level output is then recomputed.
- R11: Pending cannot be written from the register port. The status register reads 0. A write to a spare field keeps only bits 3:0 of the word.
- R12: After a synchronous active-low reset, every register reads 0 and every level output is 0.
- R13: A read from an unmapped offset returns 0, including the per-processor slots for processors at or above the processor count. A write to such an offset changes nothing.
- R14: When an incoming request and a clear of the same line (clear write or acknowledge) land on the same edge, the request wins and the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| irq_in | input | 16 | Incoming request pulses; bit k is line k, bit 0 ignored |
| ack_valid | input | NCPU | Acknowledge strobe, one bit per processor |
| ack_num | input | 4*NCPU | Acknowledged line number, 4 bits per processor |
| cpu_level | output | 4*NCPU | Presented interrupt level, 4 bits per processor |

## Verification
Several input patterns exercise the selection logic. Two non-broadcast lines with only one processor unmasked show that the highest number wins and that masking isolates processors. Setting the level bit of the lower line shows that group selection overrides numeric order. A broadcast line raised for all processors, then acknowledged by one of them, separates per-processor force state from shared pending state. Force writes that set and clear bits in the same word, the alias, the clear port and the read-only, unmapped and out-of-range offsets check the decode. A request that lands on the same edge as an acknowledge of the same line checks R14.

// File: rtl/irq_hub_pkg.sv
// Package: shared constants and helpers of the interrupt hub.
// Assumes 16-bit line vectors with bit 0 reserved and an 8-bit byte address.
package irq_hub_pkg;

    localparam int LINES_W = 16;
    localparam int NUM_W   = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;

    localparam logic [LINES_W-1:0] LINE_MASK = 16'hFFFE;

    // Offsets of the shared registers
    localparam logic [ADDR_W-1:0] OFF_GROUP  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ALIAS  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_BCAST  = 8'h14;

    // Region codes carried in address bits 7:6
    typedef enum logic [1:0] {
        REG_SHARED = 2'b00,
        REG_MASK   = 2'b01,
        REG_FORCE  = 2'b10,
        REG_SPARE  = 2'b11
    } region_e;

    // Returns the index of the highest set bit of a line vector, or 0.
    function automatic logic [NUM_W-1:0] top_line(input logic [LINES_W-1:0] v);
        logic [NUM_W-1:0] r;
        r = '0;
        for (int i = 1; i < LINES_W; i++) begin
            if (v[i]) r = NUM_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_hub_regs.sv
// Module: register file and decode of the interrupt hub.
// Holds the group, pending, broadcast, spare and per-processor mask/force
// state. It applies incoming pulses, acknowledges and register writes.
// Assumes one register access per cycle and full-word accesses only.
// Same-edge order: clears act on the old value, then sets are ORed in.
module irq_hub_regs
    import irq_hub_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [LINES_W-1:0]       irq_in,
    input  logic [NCPU-1:0]          ack_valid,
    input  logic [NCPU*NUM_W-1:0]    ack_num,
    output logic [LINES_W-1:0]       pending_o,
    output logic [LINES_W-1:0]       group_o,
    output logic [NCPU*LINES_W-1:0]  mask_o,
    output logic [NCPU*LINES_W-1:0]  force_o
);

    localparam logic [4:0] NCPU5 = 5'(NCPU);

    logic [LINES_W-1:0] pending_q, group_q, bcast_q;
    logic [LINES_W-1:0] mask_q  [NCPU];
    logic [LINES_W-1:0] force_q [NCPU];
    logic [3:0]         spare_q [NCPU];

    region_e            region;
    logic [3:0]         slot;
    logic               slot_ok;
    logic               wr_group, wr_alias, wr_clear, wr_bcast;
    logic [LINES_W-1:0] line_in, bset, pset, clr_bits, ack_any;
    logic [LINES_W-1:0] ack_bits [NCPU];
    logic [LINES_W-1:0] force_d  [NCPU];
    logic [NCPU-1:0]    wr_mask, wr_force, wr_spare;

    // Split the address into region, slot and a slot-valid flag
    always_comb begin
        region  = region_e'(addr[7:6]);
        slot    = addr[5:2];
        slot_ok = ({1'b0, slot} < NCPU5) && (addr[1:0] == 2'b00);
    end

    // Decode the shared-register write strobes
    always_comb begin
        wr_group = wr_en && (addr == OFF_GROUP);
        wr_alias = wr_en && (addr == OFF_ALIAS);
        wr_clear = wr_en && (addr == OFF_CLEAR);
        wr_bcast = wr_en && (addr == OFF_BCAST);
    end

    // Split incoming pulses into broadcast and pending sets
    always_comb begin
        line_in  = irq_in & LINE_MASK;
        bset     = line_in & bcast_q;
        pset     = line_in & ~bcast_q;
        clr_bits = wr_clear ? (wdata[LINES_W-1:0] & LINE_MASK) : '0;
    end

    // Combine the acknowledge bits of all processors for pending
    always_comb begin
        ack_any = '0;
        for (int n = 0; n < NCPU; n++) begin
            ack_any = ack_any | ack_bits[n];
        end
    end

    // Shared registers: group select, broadcast select and pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            group_q   <= '0;
            bcast_q   <= '0;
            pending_q <= '0;
        end else begin
            if (wr_group) group_q <= wdata[LINES_W-1:0] & LINE_MASK;
            if (wr_bcast) bcast_q <= wdata[LINES_W-1:0] & LINE_MASK;
            pending_q <= (pending_q & ~clr_bits & ~ack_any) | pset;
        end
    end

    for (genvar n = 0; n < NCPU; n++) begin : g_cpu
        // Per-processor write strobes and acknowledge bits
        always_comb begin
            wr_mask[n]  = wr_en && (region == REG_MASK)  && slot_ok && (slot == 4'(n));
            wr_force[n] = wr_en && (region == REG_FORCE) && slot_ok && (slot == 4'(n));
            wr_spare[n] = wr_en && (region == REG_SPARE) && slot_ok && (slot == 4'(n));
            ack_bits[n] = ack_valid[n]
                        ? ((16'h0001 << ack_num[n*NUM_W +: NUM_W]) & LINE_MASK) : '0;
        end

        // Next force value: alias, set/clear word, clears, then broadcast sets
        always_comb begin
            force_d[n] = force_q[n];
            if ((n == 0) && wr_alias) force_d[n] = wdata[LINES_W-1:0] & LINE_MASK;
            if (wr_force[n]) begin
                force_d[n] = (force_d[n] | (wdata[LINES_W-1:0] & LINE_MASK))
                           & ~(wdata[DATA_W-1:LINES_W] & LINE_MASK);
            end
            if (n == 0) force_d[n] = force_d[n] & ~clr_bits;
            force_d[n] = (force_d[n] & ~ack_bits[n]) | bset;
        end

        // Per-processor mask, force and spare registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[n]  <= '0;
                force_q[n] <= '0;
                spare_q[n] <= '0;
            end else begin
                if (wr_mask[n])  mask_q[n]  <= wdata[LINES_W-1:0] & LINE_MASK;
                if (wr_spare[n]) spare_q[n] <= wdata[3:0];
                force_q[n] <= force_d[n];
            end
        end

        assign mask_o[n*LINES_W +: LINES_W]  = mask_q[n];
        assign force_o[n*LINES_W +: LINES_W] = force_q[n];

        // R6: a broadcast pulse lands in every force register
        p_bcast_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|bset) |=> ((force_q[n] & $past(bset)) == $past(bset)));

        // R7: clear bits of a force write leave the bit at 0 unless a broadcast set it
        p_force_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_force[n] |=> ((force_q[n] & $past(wdata[DATA_W-1:LINES_W] & LINE_MASK & ~bset)) == 0));

        // R1: bit 0 of mask and force stays 0
        p_cpu_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q[n][0] == 1'b0) && (force_q[n][0] == 1'b0));
    end

    // Register read multiplexer
    always_comb begin
        rdata = '0;
        case (region)
            REG_SHARED: begin
                case (addr)
                    OFF_GROUP: rdata = {16'h0, group_q};
                    OFF_PEND:  rdata = {16'h0, pending_q};
                    OFF_ALIAS: rdata = {16'h0, force_q[0]};
                    OFF_BCAST: rdata = {16'h0, bcast_q};
                    default:   rdata = '0;
                endcase
            end
            REG_MASK:  if (slot_ok) rdata = {16'h0, mask_q[slot[$clog2(NCPU+1)-1:0] % NCPU]};
            REG_FORCE: if (slot_ok) rdata = {16'h0, force_q[slot[$clog2(NCPU+1)-1:0] % NCPU]};
            REG_SPARE: if (slot_ok) rdata = {28'h0, spare_q[slot[$clog2(NCPU+1)-1:0] % NCPU]};
            default:   rdata = '0;
        endcase
    end

    assign pending_o = pending_q;
    assign group_o   = group_q;

    // R6: a broadcast pulse does not raise pending
    p_bcast_no_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bset) |=> ((pending_q & $past(bset & ~pending_q)) == 0));

    // R9: cleared lines leave pending unless a new pulse arrived on the same edge
    p_clear_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clear |=> ((pending_q & $past(clr_bits & ~pset)) == 0));

    // R11: pending only gains bits from incoming pulses
    p_pend_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pset == 0) |=> ((pending_q & ~$past(pending_q)) == 0));

    // R14: a request on the same edge as a clear leaves the bit set
    p_set_wins_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (|pset) |=> ((pending_q & $past(pset)) == $past(pset)));

    // R1: bit 0 of the shared registers stays 0
    p_shared_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q[0] == 1'b0) && (group_q[0] == 1'b0) && (bcast_q[0] == 1'b0));

endmodule

// File: rtl/irq_hub_prio.sv
// Module: per-processor priority selector of the interrupt hub.
// Forms the active set, picks the high group when it is non-empty, and
// registers the highest candidate line number. Assumes bit 0 is unused.
module irq_hub_prio
    import irq_hub_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES_W-1:0] pending_i,
    input  logic [LINES_W-1:0] force_i,
    input  logic [LINES_W-1:0] mask_i,
    input  logic [LINES_W-1:0] group_i,
    output logic [NUM_W-1:0]   lvl_o
);

    logic [LINES_W-1:0] active, hi, cand;

    // Active set and group selection
    always_comb begin
        active = (pending_i | force_i) & mask_i & LINE_MASK;
        hi     = active & group_i;
        cand   = (hi != '0) ? hi : active;
    end

    // Registered level output
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_o <= '0;
        else        lvl_o <= top_line(cand);
    end

    // R4: when the high group is non-empty, the output is a high-group line
    p_high_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hi) |=> (((16'h0001 << lvl_o) & $past(group_i)) != 0));

    // R5: no active line gives level 0 on the next cycle
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (lvl_o == '0));

    // R3: a non-zero level names a line that was active
    p_level_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|active) |=> (((16'h0001 << lvl_o) & $past(active)) != 0));

endmodule

// File: rtl/irq_hub.sv
// Module: multiprocessor interrupt hub, top level.
// Connects the register port to the register file and builds one priority
// selector per processor. Assumes a two-phase register port with no wait
// states and no error response; reads are decoded combinationally.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [7:0]             paddr,
    input  logic [31:0]            pwdata,
    output logic [31:0]            prdata,
    input  logic [15:0]            irq_in,
    input  logic [NCPU-1:0]        ack_valid,
    input  logic [NCPU*4-1:0]      ack_num,
    output logic [NCPU*4-1:0]      cpu_level
);

    logic                     wr_en;
    logic [LINES_W-1:0]       pending_w, group_w;
    logic [NCPU*LINES_W-1:0]  mask_w, force_w;

    // Write strobe on the access phase
    assign wr_en = psel && penable && pwrite;

    irq_hub_regs #(.NCPU(NCPU)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (paddr),
        .wdata     (pwdata),
        .rdata     (prdata),
        .irq_in    (irq_in),
        .ack_valid (ack_valid),
        .ack_num   (ack_num),
        .pending_o (pending_w),
        .group_o   (group_w),
        .mask_o    (mask_w),
        .force_o   (force_w)
    );

    for (genvar n = 0; n < NCPU; n++) begin : g_prio
        irq_hub_prio u_prio (
            .clk       (clk),
            .rst_n     (rst_n),
            .pending_i (pending_w),
            .force_i   (force_w[n*LINES_W +: LINES_W]),
            .mask_i    (mask_w[n*LINES_W +: LINES_W]),
            .group_i   (group_w),
            .lvl_o     (cpu_level[n*NUM_W +: NUM_W])
        );
    end

endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;

    localparam int NCPU = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]        paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic [15:0]       irq_in = '0;
    logic [NCPU-1:0]   ack_valid = '0;
    logic [NCPU*4-1:0] ack_num = '0;
    logic [NCPU*4-1:0] cpu_level;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    irq_hub #(.NCPU(NCPU)) i_irq_hub (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_in(irq_in),
        .ack_valid(ack_valid), .ack_num(ack_num), .cpu_level(cpu_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b1;
        #1 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input logic [15:0] lines);
        @(negedge clk); irq_in = lines;
        @(negedge clk); irq_in = '0;
    endtask

    task automatic ack(input int cpu, input logic [3:0] k);
        @(negedge clk); ack_valid[cpu] = 1'b1; ack_num[cpu*4 +: 4] = k;
        @(negedge clk); ack_valid = '0;
    endtask

    task automatic lvl_check(input string req, input int cpu, input logic [3:0] exp);
        repeat (2) @(negedge clk);
        check(req, {28'h0, cpu_level[cpu*4 +: 4]}, {28'h0, exp});
    endtask

    task automatic t_reset();
        do_reset();
        rd_check("R12 group", 8'h00, 0);
        rd_check("R12 pending", 8'h04, 0);
        rd_check("R12 bcast", 8'h14, 0);
        rd_check("R12 mask1", 8'h44, 0);
        rd_check("R12 force3", 8'h8C, 0);
        check("R12 levels", {16'h0, cpu_level}, 0);
    endtask

    task automatic t_regmap();
        do_reset();
        wr(8'h00, 32'hFFFF_FFFF);
        rd_check("R1 group keeps 15:1", 8'h00, 32'h0000_FFFE);
        wr(8'h14, 32'h0001_0003);
        rd_check("R2 bcast", 8'h14, 32'h0000_0002);
        wr(8'h48, 32'h0000_1235);
        rd_check("R2 mask2", 8'h48, 32'h0000_1234);
        wr(8'hC4, 32'hFFFF_FFFF);
        rd_check("R11 spare low 4", 8'hC4, 32'h0000_000F);
        wr(8'h04, 32'h0000_FFFE);
        rd_check("R11 pending ro", 8'h04, 0);
        rd_check("R11 status", 8'h10, 0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_check("R13 unmapped", 8'h20, 0);
        wr(8'h54, 32'h0000_FFFE);
        rd_check("R13 mask slot 5", 8'h54, 0);
        rd_check("R13 mask2 untouched", 8'h48, 32'h0000_1234);
        rd_check("R13 force slot 4", 8'h90, 0);
    endtask

    task automatic t_prio();
        do_reset();
        wr(8'h40, 32'h0000_FFFE);
        pulse(16'h0208);
        rd_check("R6 pending set", 8'h04, 32'h0000_0208);
        lvl_check("R5 highest line", 0, 4'd9);
        lvl_check("R3 masked cpu", 1, 4'd0);
        wr(8'h00, 32'h0000_0008);
        lvl_check("R4 high group wins", 0, 4'd3);
        wr(8'h40, 32'h0000_FFF6);
        lvl_check("R4 low group fallback", 0, 4'd9);
        wr(8'h0C, 32'h0000_FFFF);
        rd_check("R9 pending cleared", 8'h04, 0);
        rd_check("R9 clear reads 0", 8'h0C, 0);
        lvl_check("R5 none active", 0, 4'd0);
    endtask

    task automatic t_bcast();
        do_reset();
        wr(8'h14, 32'h0000_0020);
        for (int n = 0; n < NCPU; n++) wr(8'h40 + 8'(4*n), 32'h0000_0020);
        pulse(16'h0020);
        rd_check("R6 pending untouched", 8'h04, 0);
        for (int n = 0; n < NCPU; n++) rd_check("R6 force set", 8'h80 + 8'(4*n), 32'h20);
        lvl_check("R6 cpu3 level", 3, 4'd5);
        ack(1, 4'd5);
        rd_check("R10 force1 acked", 8'h84, 0);
        rd_check("R10 force0 kept", 8'h80, 32'h20);
        lvl_check("R10 cpu1 level", 1, 4'd0);
        lvl_check("R10 cpu0 level", 0, 4'd5);
    endtask

    task automatic t_force();
        do_reset();
        wr(8'h88, 32'h0000_00C0);
        rd_check("R7 set", 8'h88, 32'h0000_00C0);
        wr(8'h88, 32'h0040_0100);
        rd_check("R7 set and clear", 8'h88, 32'h0000_0180);
        wr(8'h08, 32'h0000_0011);
        rd_check("R8 alias", 8'h80, 32'h0000_0010);
        rd_check("R8 alias read", 8'h08, 32'h0000_0010);
        wr(8'h0C, 32'h0000_0010);
        rd_check("R9 force0 cleared", 8'h80, 0);
        rd_check("R9 force2 kept", 8'h88, 32'h0000_0180);
    endtask

    task automatic t_ack();
        do_reset();
        wr(8'h4C, 32'h0000_0080);
        pulse(16'h0081);
        rd_check("R1 line 0 ignored", 8'h04, 32'h0000_0080);
        lvl_check("R3 cpu3 level", 3, 4'd7);
        ack(3, 4'd7);
        rd_check("R10 pending acked", 8'h04, 0);
        pulse(16'h0004);
        @(negedge clk); irq_in = 16'h0004; ack_valid[0] = 1'b1; ack_num[3:0] = 4'd2;
        @(negedge clk); irq_in = '0; ack_valid = '0;
        rd_check("R14 request beats ack", 8'h04, 32'h0000_0004);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL R12 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_regmap();
        t_prio();
        t_bcast();
        t_force();
        t_ack();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule